// File: doc/BRIEF.md
# Exception Priority and Entry Controller

This block sits beside the fetch and execute stages of a 32-bit core and decides when the core must leave its normal instruction stream for an exception handler. Request pulses from seven sources are latched into a pending set. At each instruction boundary the block grants the highest-priority request that the current status word allows. A reset request is granted at once and does not wait for a boundary.

A grant starts the entry sequence, and its results appear on registered outputs one clock later, as a one-cycle redirect pulse. The outputs carry the handler vector address, the status word the core must load, and the target processor mode. For every source except reset they also carry the old status word and the return address, which the core banks into the target mode's saved-status and link registers. A reset entry instead loads a fixed known status word and drops every other pending request.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst` is high, and in every cycle where `redirect_vld_o` is low, all data outputs (`vec_addr_o`, `new_psr_o`, `saved_psr_o`, `link_val_o`, `tgt_mode_o`, `bank_we_o`) are zero.
- R2: Request bits map as bit0 reset, bit1 data abort, bit2 fast interrupt, bit3 normal interrupt, bit4 prefetch abort, bit5 software interrupt, bit6 undefined instruction. When several are eligible at one grant, the lowest bit index wins.
- R3: A reset request (bit0) is granted on the next clock edge whether or not `insn_bnd_i` is high and even while a redirect is active. It clears every pending request. The next cycle shows vector `VEC_BASE`, mode 0x13, new status 0x000000D3, and zero saved status, link and `bank_we_o`.
- R4: A non-reset request is granted only on a clock edge where `insn_bnd_i` is high and `redirect_vld_o` is low. Its outputs appear for exactly one cycle after that edge.
- R5: A request pulse that is not granted stays pending until it is granted or a reset entry clears it.
- R6: The normal interrupt (bit3) is eligible only while `cur_psr_i[7]` is 0, and the fast interrupt (bit2) only while `cur_psr_i[6]` is 0. A masked interrupt stays pending.
- R7: Target mode and vector offset from `VEC_BASE` are: data abort 0x17/0x10, fast interrupt 0x11/0x1C, normal interrupt 0x12/0x18, prefetch abort 0x17/0x0C, software interrupt 0x13/0x08, undefined 0x1B/0x04.
- R8: For a non-reset entry, `new_psr_o` equals the status word sampled at the grant edge, changed as follows: bits [4:0] become the target mode, bit5 (T) is cleared, bit7 (I) is set, and bit6 (F) is set for a fast interrupt entry and otherwise copied.
- R9: For a non-reset entry, `saved_psr_o` and `link_val_o` equal `cur_psr_i` and `ret_addr_i` sampled at the grant edge, and `bank_we_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req_i | input | NUM_EXC (7) | Exception request pulses, bit map in R2 |
| cur_psr_i | input | XLEN (32) | Current status word |
| ret_addr_i | input | XLEN (32) | Return address to bank on entry |
| insn_bnd_i | input | 1 | Instruction boundary strobe |
| redirect_vld_o | output | 1 | One-cycle fetch redirect pulse |
| vec_addr_o | output | XLEN (32) | Handler vector address |
| new_psr_o | output | XLEN (32) | Status word to load |
| saved_psr_o | output | XLEN (32) | Status word to bank in the target mode |
| link_val_o | output | XLEN (32) | Link value to bank in the target mode |
| tgt_mode_o | output | 5 | Target mode code |
| bank_we_o | output | 1 | Saved status and link are to be written |

## Verification
The assertions assume that the request pulses, the status word and the boundary strobe are stable around each rising edge, and that the status word seen at a grant is the one the entry must use. The bench drives every input on the falling edge, one full cycle per vector. It also keeps the status word constant over each vector in which a grant may happen. The bench raises the boundary strobe in the cycle right after a redirect on purpose, so that the one-cycle lockout after a redirect is exercised without breaking these assumptions.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int NUM_EXC = 7;
  localparam int MODE_W  = 5;
  localparam int PSR_T   = 5;
  localparam int PSR_F   = 6;
  localparam int PSR_I   = 7;

  typedef enum logic [2:0] {
    EXC_RESET = 3'd0,
    EXC_DABT  = 3'd1,
    EXC_FIQ   = 3'd2,
    EXC_IRQ   = 3'd3,
    EXC_PABT  = 3'd4,
    EXC_SWI   = 3'd5,
    EXC_UNDEF = 3'd6
  } exc_e;

  localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
  localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;

  function automatic logic [MODE_W-1:0] exc_mode(exc_e e);
    case (e)
      EXC_DABT, EXC_PABT: return MODE_ABT;
      EXC_FIQ:            return MODE_FIQ;
      EXC_IRQ:            return MODE_IRQ;
      EXC_UNDEF:          return MODE_UND;
      default:            return MODE_SVC;
    endcase
  endfunction

  function automatic logic [7:0] exc_vec_off(exc_e e);
    case (e)
      EXC_UNDEF: return 8'h04;
      EXC_SWI:   return 8'h08;
      EXC_PABT:  return 8'h0C;
      EXC_DABT:  return 8'h10;
      EXC_IRQ:   return 8'h18;
      EXC_FIQ:   return 8'h1C;
      default:   return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/exc_pend_arb.sv
module exc_pend_arb
  import exc_pkg::*;
#(
  parameter int NUM = NUM_EXC
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NUM-1:0] req_i,
  input  logic           bnd_i,
  input  logic           busy_i,
  input  logic           irq_mask_i,
  input  logic           fiq_mask_i,
  output logic           take_o,
  output exc_e           win_o,
  output logic [NUM-1:0] grant_o
);

  localparam int IDX_W = $clog2(NUM);

  logic [NUM-1:0]   pend_q;
  logic [NUM-1:0]   eff;
  logic [NUM-1:0]   elig;
  logic [IDX_W-1:0] idx;
  logic             found;
  logic             open_w;

  assign eff    = pend_q | req_i;
  assign open_w = bnd_i & ~busy_i;

  // Eligibility per source: reset always, interrupts gated by their masks.
  for (genvar g = 0; g < NUM; g++) begin : g_elig
    if (g == int'(EXC_RESET)) begin : g_rst
      assign elig[g] = eff[g];
    end else if (g == int'(EXC_IRQ)) begin : g_irq
      assign elig[g] = eff[g] & open_w & ~irq_mask_i;
    end else if (g == int'(EXC_FIQ)) begin : g_fiq
      assign elig[g] = eff[g] & open_w & ~fiq_mask_i;
    end else begin : g_sync
      assign elig[g] = eff[g] & open_w;
    end
  end

  // Fixed priority: lowest index wins.
  always_comb begin
    grant_o = '0;
    found   = 1'b0;
    idx     = '0;
    for (int i = 0; i < NUM; i++) begin
      if (elig[i] && !found) begin
        grant_o[i] = 1'b1;
        found      = 1'b1;
        idx        = IDX_W'(i);
      end
    end
  end

  assign take_o = found;
  assign win_o  = exc_e'(idx);

  always_ff @(posedge clk) begin
    if (rst)                 pend_q <= '0;
    else if (eff[EXC_RESET]) pend_q <= '0;
    else                     pend_q <= eff & ~grant_o;
  end

  logic live_q;
  always_ff @(posedge clk) begin
    if (rst) live_q <= 1'b0;
    else     live_q <= 1'b1;
  end

  a_r2_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));

  a_r6_irq_masked: assert property (@(posedge clk) disable iff (rst)
    irq_mask_i |-> !grant_o[EXC_IRQ]);

  a_r6_fiq_masked: assert property (@(posedge clk) disable iff (rst)
    fiq_mask_i |-> !grant_o[EXC_FIQ]);

  a_r5_keep_pending: assert property (@(posedge clk) disable iff (rst || !live_q)
    !$past(eff[EXC_RESET]) |-> ((pend_q & $past(eff & ~grant_o)) == $past(eff & ~grant_o)));

  a_r3_reset_flush: assert property (@(posedge clk) disable iff (rst)
    eff[EXC_RESET] |=> (pend_q == '0));

endmodule

// File: rtl/exc_entry_gen.sv
module exc_entry_gen
  import exc_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] VEC_BASE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_i,
  input  exc_e              win_i,
  input  logic [XLEN-1:0]   cur_psr_i,
  input  logic [XLEN-1:0]   ret_addr_i,
  output logic              redirect_vld_o,
  output logic [XLEN-1:0]   vec_addr_o,
  output logic [XLEN-1:0]   new_psr_o,
  output logic [XLEN-1:0]   saved_psr_o,
  output logic [XLEN-1:0]   link_val_o,
  output logic [MODE_W-1:0] tgt_mode_o,
  output logic              bank_we_o
);

  logic [MODE_W-1:0] mode_c;
  logic [XLEN-1:0]   vec_c, npsr_c, spsr_c, link_c;
  logic              we_c;

  always_comb begin
    mode_c = exc_mode(win_i);
    vec_c  = VEC_BASE + XLEN'(exc_vec_off(win_i));
    if (win_i == EXC_RESET) begin
      npsr_c                 = '0;
      npsr_c[MODE_W-1:0]     = MODE_SVC;
      npsr_c[PSR_I]          = 1'b1;
      npsr_c[PSR_F]          = 1'b1;
      spsr_c                 = '0;
      link_c                 = '0;
      we_c                   = 1'b0;
    end else begin
      npsr_c                 = cur_psr_i;
      npsr_c[MODE_W-1:0]     = mode_c;
      npsr_c[PSR_T]          = 1'b0;
      npsr_c[PSR_I]          = 1'b1;
      if (win_i == EXC_FIQ) npsr_c[PSR_F] = 1'b1;
      spsr_c                 = cur_psr_i;
      link_c                 = ret_addr_i;
      we_c                   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !take_i) begin
      redirect_vld_o <= 1'b0;
      vec_addr_o     <= '0;
      new_psr_o      <= '0;
      saved_psr_o    <= '0;
      link_val_o     <= '0;
      tgt_mode_o     <= '0;
      bank_we_o      <= 1'b0;
    end else begin
      redirect_vld_o <= 1'b1;
      vec_addr_o     <= vec_c;
      new_psr_o      <= npsr_c;
      saved_psr_o    <= spsr_c;
      link_val_o     <= link_c;
      tgt_mode_o     <= mode_c;
      bank_we_o      <= we_c;
    end
  end

  logic live_q;
  always_ff @(posedge clk) begin
    if (rst) live_q <= 1'b0;
    else     live_q <= 1'b1;
  end

  a_r8_irq_off: assert property (@(posedge clk) disable iff (rst)
    redirect_vld_o |-> new_psr_o[PSR_I]);

  a_r8_thumb_off: assert property (@(posedge clk) disable iff (rst)
    redirect_vld_o |-> !new_psr_o[PSR_T]);

  a_r8_fiq_both_off: assert property (@(posedge clk) disable iff (rst)
    (redirect_vld_o && tgt_mode_o == MODE_FIQ) |-> new_psr_o[PSR_F]);

  a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !redirect_vld_o |-> (vec_addr_o == '0 && new_psr_o == '0 && !bank_we_o));

  a_r9_banked_psr: assert property (@(posedge clk) disable iff (rst || !live_q)
    (redirect_vld_o && bank_we_o) |-> (saved_psr_o == $past(cur_psr_i)
                                       && link_val_o == $past(ret_addr_i)));

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              NUM_EXC  = exc_pkg::NUM_EXC,
  parameter logic [XLEN-1:0] VEC_BASE = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EXC-1:0] exc_req_i,
  input  logic [XLEN-1:0]    cur_psr_i,
  input  logic [XLEN-1:0]    ret_addr_i,
  input  logic               insn_bnd_i,
  output logic               redirect_vld_o,
  output logic [XLEN-1:0]    vec_addr_o,
  output logic [XLEN-1:0]    new_psr_o,
  output logic [XLEN-1:0]    saved_psr_o,
  output logic [XLEN-1:0]    link_val_o,
  output logic [MODE_W-1:0]  tgt_mode_o,
  output logic               bank_we_o
);

  logic               take;
  exc_e               win;
  logic [NUM_EXC-1:0] grant;

  exc_pend_arb #(.NUM(NUM_EXC)) u_arb (
    .clk        (clk),
    .rst        (rst),
    .req_i      (exc_req_i),
    .bnd_i      (insn_bnd_i),
    .busy_i     (redirect_vld_o),
    .irq_mask_i (cur_psr_i[PSR_I]),
    .fiq_mask_i (cur_psr_i[PSR_F]),
    .take_o     (take),
    .win_o      (win),
    .grant_o    (grant)
  );

  exc_entry_gen #(.XLEN(XLEN), .VEC_BASE(VEC_BASE)) u_gen (
    .clk            (clk),
    .rst            (rst),
    .take_i         (take),
    .win_i          (win),
    .cur_psr_i      (cur_psr_i),
    .ret_addr_i     (ret_addr_i),
    .redirect_vld_o (redirect_vld_o),
    .vec_addr_o     (vec_addr_o),
    .new_psr_o      (new_psr_o),
    .saved_psr_o    (saved_psr_o),
    .link_val_o     (link_val_o),
    .tgt_mode_o     (tgt_mode_o),
    .bank_we_o      (bank_we_o)
  );

  logic live_q;
  always_ff @(posedge clk) begin
    if (rst) live_q <= 1'b0;
    else     live_q <= 1'b1;
  end

  a_r3_reset_wins: assert property (@(posedge clk) disable iff (rst)
    exc_req_i[0] |=> (redirect_vld_o && !bank_we_o && tgt_mode_o == MODE_SVC
                      && vec_addr_o == VEC_BASE));

  a_r4_boundary_only: assert property (@(posedge clk) disable iff (rst || !live_q)
    (redirect_vld_o && bank_we_o) |-> ($past(insn_bnd_i) && !$past(redirect_vld_o)));

  a_r6_irq_enabled: assert property (@(posedge clk) disable iff (rst || !live_q)
    (redirect_vld_o && tgt_mode_o == MODE_IRQ) |-> !$past(cur_psr_i[PSR_I]));

  a_r2_grant_matches: assert property (@(posedge clk) disable iff (rst)
    take |-> (grant != '0));

endmodule

// File: tb/exc_entry_ctrl_tb_top.sv
module exc_entry_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  req_d = '0;
  logic [31:0] psr_d = '0;
  logic [31:0] ra_d  = '0;
  logic        bnd_d = 1'b0;

  logic        vld;
  logic [31:0] vec, npsr, spsr, link;
  logic [4:0]  mode;
  logic        we;

  always #5 clk = ~clk;

  exc_entry_ctrl dut_i (
    .clk(clk), .rst(rst), .exc_req_i(req_d), .cur_psr_i(psr_d), .ret_addr_i(ra_d),
    .insn_bnd_i(bnd_d), .redirect_vld_o(vld), .vec_addr_o(vec), .new_psr_o(npsr),
    .saved_psr_o(spsr), .link_val_o(link), .tgt_mode_o(mode), .bank_we_o(we)
  );

  typedef struct {
    logic        vld;
    logic        we;
    logic [4:0]  mode;
    logic [31:0] vec;
    logic [31:0] npsr;
    logic [31:0] spsr;
    logic [31:0] link;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t mon_e;
  int   n_vec = 0;
  int   n_bad = 0;
  logic [6:0] m_pend = '0;
  logic       m_busy = 1'b0;

  localparam logic [31:0] P0 = 32'h6000_0010;

  // Expected entry from the R3, R7, R8 and R9 tables.
  function automatic exp_t mk(int w, logic [31:0] psr, logic [31:0] ra);
    exp_t e;
    logic [4:0]  md;
    logic [31:0] off;
    case (w)
      1: begin md = 5'h17; off = 32'h10; end
      2: begin md = 5'h11; off = 32'h1C; end
      3: begin md = 5'h12; off = 32'h18; end
      4: begin md = 5'h17; off = 32'h0C; end
      5: begin md = 5'h13; off = 32'h08; end
      6: begin md = 5'h1B; off = 32'h04; end
      default: begin md = 5'h13; off = 32'h00; end
    endcase
    e.vld = 1'b1; e.mode = md; e.vec = off;
    if (w == 0) begin
      e.npsr = 32'h0000_00D3; e.spsr = '0; e.link = '0; e.we = 1'b0;
    end else begin
      e.npsr = (psr & ~32'h3F) | {27'b0, md} | 32'h80 | ((w == 2) ? 32'h40 : 32'h0);
      e.spsr = psr; e.link = ra; e.we = 1'b1;
    end
    e.tag = "";
    return e;
  endfunction

  task automatic apply(input logic [6:0] req, input logic [31:0] psr,
                       input logic [31:0] ra, input logic bnd, input string tag);
    exp_t e;
    logic [6:0] eff, elig;
    int w;
    @(negedge clk);
    req_d = req; psr_d = psr; ra_d = ra; bnd_d = bnd;
    eff = m_pend | req;
    w = -1;
    if (eff[0]) w = 0;
    else if (bnd && !m_busy) begin
      elig = eff;
      if (psr[7]) elig[3] = 1'b0;
      if (psr[6]) elig[2] = 1'b0;
      for (int i = 6; i >= 1; i--) if (elig[i]) w = i;
    end
    if (w < 0) begin
      e.vld = 0; e.we = 0; e.mode = '0; e.vec = '0; e.npsr = '0; e.spsr = '0; e.link = '0;
      m_pend = eff; m_busy = 1'b0;
    end else begin
      e = mk(w, psr, ra);
      m_busy = 1'b1;
      m_pend = (w == 0) ? 7'b0 : (eff & ~(7'b1 << w));
    end
    e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares each expected item after the edge it belongs to.
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      mon_e = q.pop_front();
      n_vec++;
      if (vld !== mon_e.vld || we !== mon_e.we || mode !== mon_e.mode || vec !== mon_e.vec ||
          npsr !== mon_e.npsr || spsr !== mon_e.spsr || link !== mon_e.link) begin
        n_bad++;
        $display("FAIL %s: got vld=%b we=%b mode=%h vec=%h npsr=%h spsr=%h link=%h exp vld=%b we=%b mode=%h vec=%h npsr=%h spsr=%h link=%h",
                 mon_e.tag, vld, we, mode, vec, npsr, spsr, link,
                 mon_e.vld, mon_e.we, mon_e.mode, mon_e.vec, mon_e.npsr, mon_e.spsr, mon_e.link);
      end
    end
  end

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: got hang exp finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_vec++;
    if (vld !== 1'b0 || vec !== '0 || npsr !== '0 || we !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: got vld=%b vec=%h npsr=%h exp 0 0 0", vld, vec, npsr);
    end
    rst = 1'b0;
    apply(7'b0, P0, 32'h0, 1'b1, "R1");
    apply(7'b0, P0, 32'h0, 1'b0, "R1");

    // R7 R8 R9: each source alone
    for (int k = 1; k < 7; k++) begin
      apply(7'(1 << k), P0, 32'h1000 + 32'(k * 4), 1'b1, "R7 R8 R9");
      apply(7'b0, P0, 32'h0, 1'b1, "R4");
    end

    // R8: T cleared, flags kept; F copied on IRQ
    apply(7'b0100000, 32'hA000_0030, 32'h1100, 1'b1, "R8");
    apply(7'b0, P0, 32'h0, 1'b0, "R1");
    apply(7'b0001000, 32'h0000_0050, 32'h1200, 1'b1, "R8");
    apply(7'b0, P0, 32'h0, 1'b0, "R1");

    // R2 R5: all but reset at once, drained in priority order
    apply(7'b1111110, P0, 32'h2000, 1'b1, "R2");
    for (int k = 0; k < 5; k++) begin
      apply(7'b0, P0, 32'h0, 1'b1, "R4");
      apply(7'b0, P0, 32'h2004 + 32'(k * 4), 1'b1, "R2 R5");
    end
    apply(7'b0, P0, 32'h0, 1'b1, "R4");

    // R4 R5: no boundary, then boundary
    apply(7'b1000000, P0, 32'h3000, 1'b0, "R4");
    apply(7'b0, P0, 32'h0, 1'b0, "R4");
    apply(7'b0, P0, 32'h0, 1'b0, "R5");
    apply(7'b0, P0, 32'h3008, 1'b1, "R5");
    apply(7'b0, P0, 32'h0, 1'b1, "R4");

    // R6: masking
    apply(7'b0001000, P0 | 32'h80, 32'h4000, 1'b1, "R6");
    apply(7'b0, P0 | 32'h80, 32'h0, 1'b1, "R6");
    apply(7'b0, P0, 32'h4010, 1'b1, "R6");
    apply(7'b0, P0, 32'h0, 1'b1, "R4");
    apply(7'b0000100, P0 | 32'h40, 32'h4100, 1'b1, "R6");
    apply(7'b0001000, P0 | 32'h40, 32'h4104, 1'b1, "R6");
    apply(7'b0, P0, 32'h0, 1'b1, "R4");
    apply(7'b0, P0, 32'h4108, 1'b1, "R6");
    apply(7'b0, P0, 32'h0, 1'b1, "R4");

    // R3: reset flushes pending, ignores boundary, overrides busy
    apply(7'b1100000, P0, 32'h0, 1'b0, "R5");
    apply(7'b0000001, 32'hF000_0030, 32'h5000, 1'b0, "R3");
    apply(7'b0, P0, 32'h0, 1'b1, "R3");
    apply(7'b0, P0, 32'h0, 1'b1, "R3");
    apply(7'b0000010, P0, 32'h6000, 1'b1, "R7");
    apply(7'b0000001, P0, 32'h0, 1'b1, "R3");
    apply(7'b0, P0, 32'h0, 1'b1, "R3");
    apply(7'b0, P0, 32'h0, 1'b1, "R1");

    repeat (3) @(posedge clk);
    #3;
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R1: got %0d unchecked items exp 0", q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule